// File: doc/BRIEF.md
# Scanning Window Alarm and Interrupt Controller

This block paces conversions across a set of input channels and judges each returned sample against a per-channel acceptance window. On every tick of a base-rate strobe it may issue a convert request for the channel it currently selects. It then waits for the converter's result strobe and compares the 10-bit result against that channel's lower and upper limits. It then steps to the next channel and holds off for a programmable number of base ticks before the next request. A 3-bit rate code picks the spacing. Code 0 gives one conversion per tick, and each higher code doubles the spacing.

An out-of-window result latches a sticky alarm bit for its channel. Software clears an alarm bit by pulsing a 1 on that bit's clear line. The alarm vector is always visible on the status output. An interrupt drive output, meant to pull an open-drain line low, is active when the interrupt is enabled and an alarm is latched. An alert-response strobe releases the interrupt while alarms remain latched. The interrupt comes back only when a further alarm bit rises.

Top module: `scan_window_monitor`

## Requirements
- R1: After reset, `conv_req_o`, `ch_sel_o`, `alarm_o` and `int_drive_o` are all zero, and the first convert request goes to channel 0 on the first `tick_i` after reset.
- R2: With rate code c on `delay_code_i`, after a result is accepted the block lets 2^c − 1 base ticks pass and requests on the next tick. When results return before the next tick, consecutive requests are therefore 2^c ticks apart.
- R3: `conv_req_o` is a one-cycle pulse that occurs only in a cycle where `tick_i` is high. No new request is issued until the result of the previous one has been accepted.
- R4: In single-ended mode (`diff_mode_i` = 0), channels are visited in the order 0, 1, … up to `ch_last_i`, and then the scan wraps to 0. In paired mode (`diff_mode_i` = 1), only even channels not above `ch_last_i` are visited, and odd channels never raise an alarm.
- R5: When a result for channel k is accepted, alarm bit k is set if the result is below `lo_thr_i[k*10 +: 10]` or above `hi_thr_i[k*10 +: 10]`. A result equal to either limit raises no alarm. `alarm_o` shows the new value from the edge that accepts the result.
- R6: A latched alarm bit stays set until its `alarm_clr_i` bit is 1 on a clock edge. Clear bits at 0 leave their alarms unchanged. If a bit is set and cleared on the same edge, the set wins.
- R7: A `res_valid_i` pulse that arrives while no conversion is outstanding is ignored and changes no alarm bit.
- R8: `int_drive_o` is high only when `int_en_i` is 1, at least one alarm is latched, and no alert response is pending. `alarm_o` reports the latched alarms whatever the value of `int_en_i`.
- R9: An `alert_ack_i` pulse while any alarm is latched drops `int_drive_o` from the next cycle on. The interrupt returns only when an alarm bit goes from 0 to 1, not when an already-latched channel violates again. Clearing all alarms also drops the interrupt, and an `alert_ack_i` with no alarm latched has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Base-rate strobe, one cycle wide |
| delay_code_i | input | 3 | Rate code; the spacing is 2^code ticks |
| ch_last_i | input | 2 | Highest channel included in the scan |
| diff_mode_i | input | 1 | 1 = scan even channels only |
| int_en_i | input | 1 | Interrupt drive enable |
| lo_thr_i | input | 40 | Lower limits, 10 bits per channel, channel k at bits k*10 and up |
| hi_thr_i | input | 40 | Upper limits, same packing |
| res_i | input | 10 | Conversion result |
| res_valid_i | input | 1 | Result strobe |
| alarm_clr_i | input | 4 | Per-channel alarm clear, a 1 clears |
| alert_ack_i | input | 1 | Alert-response strobe |
| ch_sel_o | output | 2 | Channel being, or about to be, converted |
| conv_req_o | output | 1 | Convert request pulse |
| alarm_o | output | 4 | Sticky alarm status |
| int_drive_o | output | 1 | 1 = pull the interrupt line low |

## Verification
`conv_req_o` is combinational from `tick_i` and registered state, so the bench drives inputs at the falling edge and reads the request 1 ns later in that same cycle. `alarm_o` and `int_drive_o` change on the rising edge that accepts a result, a clear or an acknowledge. The bench therefore keeps a model updated from the stimulus of each cycle and compares it against the outputs at the start of the next cycle. The converter stand-in returns each result two cycles after its request, well before the next tick. This lets the request spacing be checked as exactly 4·2^c cycles, with one tick every four cycles.

// File: rtl/scan_mon_pkg.sv
package scan_mon_pkg;
  typedef enum logic {
    SEQ_WAIT = 1'b0,
    SEQ_CONV = 1'b1
  } seq_state_e;
endpackage

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import scan_mon_pkg::*;
#(
  parameter int N_CH  = 4,
  parameter int DLY_W = 3,
  parameter int CH_W  = $clog2(N_CH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [DLY_W-1:0] delay_code_i,
  input  logic [CH_W-1:0]  ch_last_i,
  input  logic             diff_mode_i,
  input  logic             res_valid_i,
  output logic [CH_W-1:0]  ch_sel_o,
  output logic             conv_req_o,
  output logic             res_take_o
);
  localparam int CNT_W = (1 << DLY_W) - 1;

  seq_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CH_W-1:0]  ch_q;

  logic [CNT_W:0]   pow2;
  logic [CNT_W-1:0] wait_len;
  logic [CH_W:0]    ch_inc;
  logic [CH_W-1:0]  ch_nxt;

  assign pow2     = (CNT_W+1)'(1) << delay_code_i;
  assign wait_len = CNT_W'(pow2 - 1'b1);
  assign ch_inc   = {1'b0, ch_q} + (diff_mode_i ? (CH_W+1)'(2) : (CH_W+1)'(1));
  assign ch_nxt   = (ch_inc > {1'b0, ch_last_i}) ? '0 : ch_inc[CH_W-1:0];

  assign conv_req_o = (st_q == SEQ_WAIT) && tick_i && (cnt_q == '0);
  assign res_take_o = (st_q == SEQ_CONV) && res_valid_i;
  assign ch_sel_o   = ch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SEQ_WAIT;
      cnt_q <= '0;
      ch_q  <= '0;
    end else if (res_take_o) begin
      st_q  <= SEQ_WAIT;
      cnt_q <= wait_len;
      ch_q  <= ch_nxt;
    end else if (conv_req_o) begin
      st_q <= SEQ_CONV;
    end else if (st_q == SEQ_WAIT && tick_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  a_r3_req_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |=> !conv_req_o);

  a_r3_hold_channel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SEQ_CONV && !res_valid_i) |=> ($stable(ch_sel_o) && !conv_req_o));

  a_r4_pairs_stay_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_take_o && diff_mode_i && !ch_sel_o[0]) |=> !ch_sel_o[0]);
endmodule

// File: rtl/window_check.sv
module window_check #(
  parameter int N_CH  = 4,
  parameter int RES_W = 10,
  parameter int CH_W  = $clog2(N_CH)
) (
  input  logic [N_CH*RES_W-1:0] lo_thr_i,
  input  logic [N_CH*RES_W-1:0] hi_thr_i,
  input  logic [CH_W-1:0]       ch_sel_i,
  input  logic [RES_W-1:0]      res_i,
  output logic                  hit_o
);
  logic [N_CH-1:0] outside;

  for (genvar k = 0; k < N_CH; k++) begin : g_cmp
    assign outside[k] = (res_i < lo_thr_i[k*RES_W +: RES_W]) ||
                        (res_i > hi_thr_i[k*RES_W +: RES_W]);
  end

  assign hit_o = outside[ch_sel_i];
endmodule

// File: rtl/alarm_irq.sv
module alarm_irq #(
  parameter int N_CH = 4,
  parameter int CH_W = $clog2(N_CH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_i,
  input  logic            hit_i,
  input  logic [CH_W-1:0] ch_sel_i,
  input  logic [N_CH-1:0] clr_i,
  input  logic            ack_i,
  input  logic            int_en_i,
  output logic [N_CH-1:0] alarm_o,
  output logic            int_drive_o
);
  logic [N_CH-1:0] alarm_q, alarm_d, set_vec, rise;
  logic            acked_q, acked_d;

  always_comb begin
    set_vec = '0;
    if (take_i && hit_i) set_vec[ch_sel_i] = 1'b1;
  end

  assign rise    = set_vec & ~alarm_q;
  assign alarm_d = (alarm_q & ~clr_i) | set_vec;

  // a fresh alarm re-arms the interrupt even if acknowledged in the same cycle
  always_comb begin
    acked_d = acked_q;
    if (rise != '0)                   acked_d = 1'b0;
    else if (alarm_d == '0)           acked_d = 1'b0;
    else if (ack_i && alarm_q != '0)  acked_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_q <= '0;
      acked_q <= 1'b0;
    end else begin
      alarm_q <= alarm_d;
      acked_q <= acked_d;
    end
  end

  assign alarm_o     = alarm_q;
  assign int_drive_o = int_en_i && (alarm_q != '0) && !acked_q;

  a_r6_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_vec) != '0) |=> ((alarm_q & $past(clr_i & ~set_vec)) == '0));

  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(alarm_q) & ~alarm_q & ~$past(clr_i)) == '0));

  a_r9_ack_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && alarm_q != '0 && rise == '0) |=> !int_drive_o);
endmodule

// File: rtl/scan_window_monitor.sv
module scan_window_monitor #(
  parameter int N_CH  = 4,
  parameter int RES_W = 10,
  parameter int DLY_W = 3,
  parameter int CH_W  = $clog2(N_CH)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic [DLY_W-1:0]      delay_code_i,
  input  logic [CH_W-1:0]       ch_last_i,
  input  logic                  diff_mode_i,
  input  logic                  int_en_i,
  input  logic [N_CH*RES_W-1:0] lo_thr_i,
  input  logic [N_CH*RES_W-1:0] hi_thr_i,
  input  logic [RES_W-1:0]      res_i,
  input  logic                  res_valid_i,
  input  logic [N_CH-1:0]       alarm_clr_i,
  input  logic                  alert_ack_i,
  output logic [CH_W-1:0]       ch_sel_o,
  output logic                  conv_req_o,
  output logic [N_CH-1:0]       alarm_o,
  output logic                  int_drive_o
);
  logic take;
  logic hit;

  scan_sequencer #(.N_CH(N_CH), .DLY_W(DLY_W), .CH_W(CH_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .delay_code_i (delay_code_i),
    .ch_last_i    (ch_last_i),
    .diff_mode_i  (diff_mode_i),
    .res_valid_i  (res_valid_i),
    .ch_sel_o     (ch_sel_o),
    .conv_req_o   (conv_req_o),
    .res_take_o   (take)
  );

  window_check #(.N_CH(N_CH), .RES_W(RES_W), .CH_W(CH_W)) u_win (
    .lo_thr_i (lo_thr_i),
    .hi_thr_i (hi_thr_i),
    .ch_sel_i (ch_sel_o),
    .res_i    (res_i),
    .hit_o    (hit)
  );

  alarm_irq #(.N_CH(N_CH), .CH_W(CH_W)) u_alm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_i      (take),
    .hit_i       (hit),
    .ch_sel_i    (ch_sel_o),
    .clr_i       (alarm_clr_i),
    .ack_i       (alert_ack_i),
    .int_en_i    (int_en_i),
    .alarm_o     (alarm_o),
    .int_drive_o (int_drive_o)
  );
endmodule

// File: tb/tb_scan_window_monitor.sv
module tb_scan_window_monitor;
  localparam int N_CH  = 4;
  localparam int RES_W = 10;
  localparam int DLY_W = 3;
  localparam int CH_W  = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                  rst_ni;
  logic                  tick_i;
  logic [DLY_W-1:0]      delay_code_i;
  logic [CH_W-1:0]       ch_last_i;
  logic                  diff_mode_i;
  logic                  int_en_i;
  logic [N_CH*RES_W-1:0] lo_thr_i;
  logic [N_CH*RES_W-1:0] hi_thr_i;
  logic [RES_W-1:0]      res_i;
  logic                  res_valid_i;
  logic [N_CH-1:0]       alarm_clr_i;
  logic                  alert_ack_i;
  logic [CH_W-1:0]       ch_sel_o;
  logic                  conv_req_o;
  logic [N_CH-1:0]       alarm_o;
  logic                  int_drive_o;

  scan_window_monitor #(.N_CH(N_CH), .RES_W(RES_W), .DLY_W(DLY_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .delay_code_i(delay_code_i),
    .ch_last_i(ch_last_i), .diff_mode_i(diff_mode_i), .int_en_i(int_en_i),
    .lo_thr_i(lo_thr_i), .hi_thr_i(hi_thr_i), .res_i(res_i), .res_valid_i(res_valid_i),
    .alarm_clr_i(alarm_clr_i), .alert_ack_i(alert_ack_i), .ch_sel_o(ch_sel_o),
    .conv_req_o(conv_req_o), .alarm_o(alarm_o), .int_drive_o(int_drive_o)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  int adc_val [N_CH];
  int pend = 0, pend_ch = 0;
  int exp_ch = 0, nreq = 0, last_req = 0;
  bit chk_rate = 0;
  bit done = 0;
  logic [N_CH-1:0] exp_alarm = '0;
  bit exp_acked = 0;

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lo_of(int k);
    return int'(lo_thr_i[k*RES_W +: RES_W]);
  endfunction

  function automatic int hi_of(int k);
    return int'(hi_thr_i[k*RES_W +: RES_W]);
  endfunction

  function automatic bit viol(int k, int v);
    return (v < lo_of(k)) || (v > hi_of(k));
  endfunction

  task automatic set_thr(int k, int lo, int hi);
    lo_thr_i[k*RES_W +: RES_W] = RES_W'(lo);
    hi_thr_i[k*RES_W +: RES_W] = RES_W'(hi);
  endtask

  task automatic step(logic [N_CH-1:0] clr, bit ack, bit stray);
    bit take;
    int tk_ch, tk_v, nx;
    logic [N_CH-1:0] set_v, rise, nxt;
    @(negedge clk);
    cyc++;
    if (rst_ni) begin
      check(alarm_o == exp_alarm, "R5 R6 alarm", alarm_o, exp_alarm);
      check(int_drive_o == (int_en_i && exp_alarm != '0 && !exp_acked),
            "R8 R9 int", int_drive_o, int'(int_en_i && exp_alarm != '0 && !exp_acked));
    end
    tick_i = (cyc % 4 == 0);
    take = 0; tk_ch = 0; tk_v = 0;
    if (pend == 1) begin
      take = 1; tk_ch = pend_ch; tk_v = adc_val[pend_ch];
      res_valid_i = 1'b1; res_i = RES_W'(tk_v); pend = 0;
    end else begin
      if (pend > 1) pend--;
      res_valid_i = stray;
      res_i = stray ? 10'd1023 : 10'd0;
    end
    alarm_clr_i = clr;
    alert_ack_i = ack;
    #1;
    if (conv_req_o) begin
      check(tick_i == 1'b1, "R3 request on tick", tick_i, 1);
      check(pend == 0 && !take, "R3 one outstanding", pend, 0);
      check(int'(ch_sel_o) == exp_ch, "R4 channel order", ch_sel_o, exp_ch);
      if (chk_rate && nreq >= 1)
        check(cyc - last_req == (4 << delay_code_i), "R2 request spacing",
              cyc - last_req, 4 << delay_code_i);
      last_req = cyc; nreq++; pend = 2; pend_ch = int'(ch_sel_o);
      nx = exp_ch + (diff_mode_i ? 2 : 1);
      exp_ch = (nx > int'(ch_last_i)) ? 0 : nx;
    end
    set_v = '0;
    if (take && viol(tk_ch, tk_v)) set_v[tk_ch] = 1'b1;
    rise = set_v & ~exp_alarm;
    nxt  = (exp_alarm & ~clr) | set_v;
    if (rise != '0) exp_acked = 0;
    else if (nxt == '0) exp_acked = 0;
    else if (ack && exp_alarm != '0) exp_acked = 1;
    exp_alarm = nxt;
  endtask

  task automatic run(int n);
    repeat (n) step('0, 1'b0, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; tick_i = 1'b0; res_valid_i = 1'b0;
    alarm_clr_i = '0; alert_ack_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    pend = 0; exp_ch = 0; nreq = 0; exp_alarm = '0; exp_acked = 0;
    #1;
    check(conv_req_o == 1'b0, "R1 request idle", conv_req_o, 0);
    check(ch_sel_o == '0, "R1 channel zero", ch_sel_o, 0);
    check(alarm_o == '0, "R1 alarms clear", alarm_o, 0);
    check(int_drive_o == 1'b0, "R1 int released", int_drive_o, 0);
  endtask

  task automatic set_all(int v);
    for (int k = 0; k < N_CH; k++) adc_val[k] = v;
  endtask

  initial begin
    rst_ni = 1'b0; tick_i = 1'b0; delay_code_i = '0; ch_last_i = 2'd3;
    diff_mode_i = 1'b0; int_en_i = 1'b0; res_i = '0; res_valid_i = 1'b0;
    alarm_clr_i = '0; alert_ack_i = 1'b0;
    for (int k = 0; k < N_CH; k++) set_thr(k, 0, 1023);
    set_all(500);

    // R2: every rate code
    chk_rate = 1;
    for (int c = 0; c < 8; c++) begin
      delay_code_i = DLY_W'(c);
      do_reset();
      while (nreq < 5) step('0, 1'b0, 1'b0);
    end
    chk_rate = 0;
    delay_code_i = '0;

    // R4: every scan limit in both modes
    for (int d = 0; d < 2; d++) begin
      for (int l = 0; l < 4; l++) begin
        diff_mode_i = d[0];
        ch_last_i = CH_W'(l);
        do_reset();
        while (nreq < 9) step('0, 1'b0, 1'b0);
      end
    end
    diff_mode_i = 1'b0; ch_last_i = 2'd3;

    // R5: values at and beyond each limit
    for (int k = 0; k < N_CH; k++) set_thr(k, 100 + 40*k, 400 + 40*k);
    int_en_i = 1'b1;
    do_reset();
    for (int s = 0; s < 6; s++) begin
      logic [N_CH-1:0] want;
      for (int k = 0; k < N_CH; k++) begin
        case (s)
          0: adc_val[k] = lo_of(k) - 1;
          1: adc_val[k] = lo_of(k);
          2: adc_val[k] = hi_of(k);
          3: adc_val[k] = hi_of(k) + 1;
          4: adc_val[k] = (lo_of(k) + hi_of(k)) / 2;
          default: adc_val[k] = (k % 2 == 0) ? 0 : 1023;
        endcase
      end
      run(24);
      want = (s == 1 || s == 2 || s == 4) ? 4'h0 : 4'hF;
      check(alarm_o == want, "R5 window limits", alarm_o, want);
      set_all(250);
      step(4'hF, 1'b0, 1'b0);
      run(2);
      check(alarm_o == 4'h0, "R6 clear all", alarm_o, 0);
    end

    // R6: partial clear, and clears pulsed during live violations
    set_all(0);
    run(24);
    set_all(250);
    step(4'b0101, 1'b0, 1'b0);
    step('0, 1'b0, 1'b0);
    check(alarm_o == 4'b1010, "R6 zero bits keep alarms", alarm_o, 4'b1010);
    set_all(0);
    repeat (24) step(4'hF, 1'b0, 1'b0);
    set_all(250);
    step(4'hF, 1'b0, 1'b0);
    run(2);

    // R9: acknowledge, re-arm on new bit only
    adc_val[1] = 0;
    run(24);
    check(int_drive_o == 1'b1, "R8 int on alarm", int_drive_o, 1);
    step('0, 1'b1, 1'b0);
    step('0, 1'b0, 1'b0);
    check(int_drive_o == 1'b0, "R9 ack releases", int_drive_o, 0);
    run(24);
    check(int_drive_o == 1'b0, "R9 latched repeat stays quiet", int_drive_o, 0);
    adc_val[2] = 1023;
    run(24);
    check(int_drive_o == 1'b1, "R9 new alarm rearms", int_drive_o, 1);
    set_all(250);
    step(4'hF, 1'b0, 1'b0);
    step('0, 1'b0, 1'b0);
    check(int_drive_o == 1'b0, "R9 clear all releases", int_drive_o, 0);
    step('0, 1'b1, 1'b0);
    adc_val[3] = 0;
    run(24);
    check(int_drive_o == 1'b1, "R9 idle ack no effect", int_drive_o, 1);
    set_all(250);
    step(4'hF, 1'b0, 1'b0);

    // R8: disabled interrupt, status still visible
    int_en_i = 1'b0;
    adc_val[0] = 0;
    run(24);
    check(alarm_o == 4'b0001, "R8 status readable", alarm_o, 1);
    check(int_drive_o == 1'b0, "R8 disabled int", int_drive_o, 0);
    int_en_i = 1'b1;
    set_all(250);
    step(4'hF, 1'b0, 1'b0);

    // R7: stray result strobes while idle
    delay_code_i = 3'd2;
    do_reset();
    repeat (80) step('0, 1'b0, pend == 0);
    check(alarm_o == 4'h0, "R7 stray strobe ignored", alarm_o, 0);

    // R4: odd channels never scanned in paired mode
    delay_code_i = '0;
    diff_mode_i = 1'b1;
    do_reset();
    adc_val[1] = 0; adc_val[3] = 1023;
    run(40);
    check(alarm_o == 4'h0, "R4 odd channels skipped", alarm_o, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R3 watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule